// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit frames from a clocked synchronous serial link. Each data bit is captured on a rising edge of a synchronization clock. That clock either arrives on a pin, where a two-flop synchronizer brings it into the system clock domain, or comes from an internal divider whose output is driven out of the block. Bits gather in a shift register. When a frame completes, the byte moves to a data register, and a full flag marks it as waiting for software.

Software reads the byte and the status through a small register port and clears flags by writing 0 to them. If a second frame completes while the full flag is still set, the new byte is discarded, the overrun flag is raised and reception halts. It stays halted until software has cleared every error flag and the full flag. Two level interrupt requests, one for data ready and one for errors, share a single enable bit.

A controller state machine sequences the receiver through four states:

- **ST_IDLE**: reception is off.
- **ST_INIT**: one cycle of initialization that clears the bit counter and starts the internal divider.
- **ST_RECV**: bits are shifted in.
- **ST_HALT**: entered on overrun.

The transitions are:

- **go**: ST_IDLE to ST_INIT, taken when rx_en is 1 and no flag is set.
- **arm**: ST_INIT to ST_RECV, taken when rx_en is 1.
- **overrun**: ST_RECV to ST_HALT, taken when a frame completes with the full flag set.
- **resume**: ST_HALT to ST_INIT, taken when rx_en is 1 and all flags are clear.
- **stop**: any state to ST_IDLE, taken when rx_en is 0.

Top module: `sync_serial_rx`

## Requirements
- R1: A frame is 8 bits received least significant bit first: the first sampled bit becomes bit 0 of the byte and the eighth becomes bit 7.
- R2: When a frame completes while the full flag (status bit 0) is 0, the byte is written to the data register (read at address 0) and the full flag becomes 1; the data register changes at no other time.
- R3: When a frame completes while the full flag is 1, the overrun flag (status bit 1) becomes 1, the new byte is discarded, and both the data register and the full flag keep their values.
- R4: irq_rx is 1 exactly while the interrupt enable (control register, address 2, bit 0) and the full flag are both 1; irq_err is 1 exactly while the enable is 1 and any of the overrun, framing (bit 2) or parity (bit 3) flags is 1.
- R5: After an overrun, frames arriving on the link do not change the data register or the flags, until all of status bits 0 to 3 have been cleared; reception then resumes.
- R6: Writing the status register (address 1) clears each flag whose written bit is 0; a written 1 leaves the flag unchanged and never sets it.
- R7: Driving rx_en low discards a partial frame (bit counter and shift register cleared) and leaves all status flags unchanged.
- R8: In pin-clock mode (clk_sel = 0), a rising edge on sck_in is detected through a two-flop synchronizer; the eighth bit's edge sets the full flag on the third system clock edge after sck_in rises.
- R9: In internal-clock mode (clk_sel = 1), sck_out idles low and toggles every HALF_DIV system cycles (default 4) while receiving; bits are sampled on its rising edges.
- R10: After reset, the data register, all flags, the interrupt enable, irq_rx, irq_err and sck_out are 0.
- R11: Reception starts (ST_IDLE to ST_INIT) only when rx_en is 1 and status bits 0 to 3 are all 0; otherwise incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| clk_sel | input | 1 | 0: sync clock from sck_in; 1: internal divider |
| sck_in | input | 1 | External synchronization clock |
| sdata_in | input | 1 | Serial data |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| sck_out | output | 1 | Internally generated synchronization clock |
| irq_rx | output | 1 | Receive-complete interrupt request (level) |
| irq_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The assertions assume three things about the environment. Software never clears the full flag in the same cycle that a frame completes. sck_in and sdata_in stay stable for several system cycles around each sync clock edge. rx_en is not toggled in the middle of a bit.

The bench respects these assumptions in its stimulus:

- Each sync clock phase lasts six system cycles.
- Data changes only while the sync clock is low.
- In internal mode, data is changed just after a falling edge of sck_out.
- Register writes happen only after the link has been idle for several cycles.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_RECV = 2'd2,
        ST_HALT = 2'd3
    } rx_state_e;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] A_DATA = 2'd0;
    localparam logic [REG_AW-1:0] A_STAT = 2'd1;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd2;

    localparam int SB_FULL = 0;
    localparam int SB_OVR  = 1;
    localparam int SB_FER  = 2;
    localparam int SB_PER  = 3;
    localparam int CB_IEN  = 0;
endpackage

// File: rtl/ssrx_clkgen.sv
module ssrx_clkgen #(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_int,
    input  logic run,
    input  logic sck_pin,
    input  logic sdata_pin,
    output logic sck_drv,
    output logic samp_pulse,
    output logic sdata_sync
);
    localparam int DCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DCW-1:0] DLAST = DCW'(HALF_DIV - 1);

    logic [SYNC_STAGES-1:0] sck_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic                   sck_prev;
    logic [DCW-1:0]         div_cnt;
    logic                   ext_rise;
    logic                   int_rise;

    // Synchronizer chains for clock and data, kept equal in length.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_sync[g] <= 1'b0;
                    dat_sync[g] <= 1'b0;
                end else if (g == 0) begin
                    sck_sync[g] <= sck_pin;
                    dat_sync[g] <= sdata_pin;
                end else begin
                    sck_sync[g] <= sck_sync[(g > 0) ? g - 1 : 0];
                    dat_sync[g] <= dat_sync[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_sync[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sck_sync[SYNC_STAGES-1] & ~sck_prev;

    // Internal divider: idle low, toggles every HALF_DIV cycles while run.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_drv <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            sck_drv <= 1'b0;
        end else if (div_cnt == DLAST) begin
            div_cnt <= '0;
            sck_drv <= ~sck_drv;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign int_rise   = run & (div_cnt == DLAST) & ~sck_drv;
    assign samp_pulse = use_int ? int_rise : ext_rise;
    assign sdata_sync = dat_sync[SYNC_STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               din,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_byte
);
    localparam int CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CW-1:0] CLAST = CW'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr;
    logic [CW-1:0]      bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else if (shift_en) begin
            sr      <= {din, sr[FRAME_W-1:1]};
            bit_cnt <= (bit_cnt == CLAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Completion is flagged in the cycle the counter wraps.
    assign frame_done = shift_en & (bit_cnt == CLAST);
    assign frame_byte = {din, sr[FRAME_W-1:1]};
endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
    import ssrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      use_int,
    input  logic      blocked,
    input  logic      ovr_evt,
    output rx_state_e state,
    output logic      shift_gate,
    output logic      clear_shift,
    output logic      clk_run
);
    rx_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (rx_en && !blocked) nxt = ST_INIT;
            ST_INIT: nxt = rx_en ? ST_RECV : ST_IDLE;
            ST_RECV: begin
                if (!rx_en)       nxt = ST_IDLE;
                else if (ovr_evt) nxt = ST_HALT;
            end
            ST_HALT: begin
                if (!rx_en)        nxt = ST_IDLE;
                else if (!blocked) nxt = ST_INIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        shift_gate  = 1'b0;
        clear_shift = 1'b1;
        clk_run     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_INIT: clk_run = rx_en & use_int;
            ST_RECV: begin
                shift_gate  = rx_en;
                clear_shift = ~rx_en;
                clk_run     = rx_en & use_int;
            end
            ST_HALT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/ssrx_regs.sv
module ssrx_regs
    import ssrx_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] frame_byte,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic [FRAME_W-1:0] rx_data,
    output logic               full,
    output logic               ovr,
    output logic               blocked,
    output logic               irq_en,
    output logic               irq_rx,
    output logic               irq_err
);
    logic fer;
    logic per;
    logic unused_wd;

    assign unused_wd = ^wr_data[7:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            ovr     <= 1'b0;
            fer     <= 1'b0;
            per     <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            if (wr_en && addr == A_STAT) begin
                full <= full & wr_data[SB_FULL];
                ovr  <= ovr  & wr_data[SB_OVR];
                fer  <= fer  & wr_data[SB_FER];
                per  <= per  & wr_data[SB_PER];
            end
            if (wr_en && addr == A_CTRL) begin
                irq_en <= wr_data[CB_IEN];
            end
            if (frame_done) begin
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    rx_data <= frame_byte;
                    full    <= 1'b1;
                end
            end
        end
    end

    assign blocked = full | ovr | fer | per;
    assign irq_rx  = irq_en & full;
    assign irq_err = irq_en & (ovr | fer | per);

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_DATA:  rd_data = 8'(rx_data);
            A_STAT:  rd_data = {4'b0, per, fer, ovr, full};
            A_CTRL:  rd_data = {7'b0, irq_en};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssrx_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             clk_sel,
    input  logic             sck_in,
    input  logic             sdata_in,
    input  logic             wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             sck_out,
    output logic             irq_rx,
    output logic             irq_err
);
    rx_state_e          state;
    logic               shift_gate;
    logic               clear_shift;
    logic               clk_run;
    logic               samp_pulse;
    logic               sdata_sync;
    logic               frame_done;
    logic [FRAME_W-1:0] frame_byte;
    logic [FRAME_W-1:0] rx_data;
    logic               full;
    logic               ovr;
    logic               blocked;
    logic               irq_en;

    ssrx_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_int    (clk_sel),
        .run        (clk_run),
        .sck_pin    (sck_in),
        .sdata_pin  (sdata_in),
        .sck_drv    (sck_out),
        .samp_pulse (samp_pulse),
        .sdata_sync (sdata_sync)
    );

    ssrx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .use_int     (clk_sel),
        .blocked     (blocked),
        .ovr_evt     (frame_done & full),
        .state       (state),
        .shift_gate  (shift_gate),
        .clear_shift (clear_shift),
        .clk_run     (clk_run)
    );

    ssrx_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_shift),
        .shift_en   (samp_pulse & shift_gate),
        .din        (sdata_sync),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    ssrx_regs #(.FRAME_W(FRAME_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_byte (frame_byte),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rx_data    (rx_data),
        .full       (full),
        .ovr        (ovr),
        .blocked    (blocked),
        .irq_en     (irq_en),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );
endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk
    import ssrx_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_en,
    input logic               irq_en,
    input logic               irq_rx,
    input logic               irq_err,
    input logic               full,
    input logic               ovr,
    input logic               frame_done,
    input logic [FRAME_W-1:0] frame_byte,
    input logic [FRAME_W-1:0] rx_data,
    input rx_state_e          state
);
    p_load_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !full) |=> (full && rx_data == $past(frame_byte)));

    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_data));

    p_keep_on_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && full) |=> (full && ovr && $stable(rx_data)));

    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!irq_rx && !irq_err));

    p_halt_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !frame_done);

    p_disable_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE));

    p_start_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |-> (!full && !ovr));
endmodule

bind sync_serial_rx ssrx_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .irq_en     (irq_en),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err),
    .full       (full),
    .ovr        (ovr),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .rx_data    (rx_data),
    .state      (state)
);

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       clk_sel = 1'b0;
    logic       sck_in = 1'b0;
    logic       sdata_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sck_out;
    logic       irq_rx;
    logic       irq_err;

    int n_chk = 0;
    int n_fail = 0;

    // bit 8 = interrupt enable, bits 7:0 = byte sent
    localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h05A, 9'h100, 9'h0FF, 9'h101, 9'h180};

    always #4 clk = ~clk;

    sync_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_sel(clk_sel),
        .sck_in(sck_in), .sdata_in(sdata_in), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .sck_out(sck_out),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdata_in = b; sck_in = 1'b0;
        repeat (6) @(negedge clk);
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
        sck_in = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic send_int(input logic [7:0] b, output int hi_cycles);
        clk_sel = 1'b1;
        sdata_in = b[0];
        @(negedge clk);
        rx_en = 1'b1;
        for (int i = 1; i < 8; i++) begin
            @(negedge sck_out);
            #1 sdata_in = b[i];
        end
        @(posedge sck_out);
        hi_cycles = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sck_out) hi_cycles++;
            else break;
        end
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        clk_sel = 1'b0;
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int hc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(2'd0, v); check("R10 data", v, 8'h00);
        rd(2'd1, v); check("R10 status", v, 8'h00);
        rd(2'd2, v); check("R10 ctrl", v, 8'h00);
        check("R10 irq/sck", {5'b0, irq_rx, irq_err, sck_out}, 8'h00);

        // Vector table: R1 ordering, R2 load, R4 irq_rx gating
        rx_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, {7'b0, VEC[i][8]});
            send_byte(VEC[i][7:0]);
            rd(2'd0, v); check("R1 byte", v, VEC[i][7:0]);
            rd(2'd1, v); check("R2 full", v, 8'h01);
            check("R4 irq_rx", {6'b0, irq_rx, irq_err}, {6'b0, VEC[i][8], 1'b0});
            wr(2'd1, 8'h00);
            rd(2'd1, v); check("R6 clear", v, 8'h00);
        end

        // R8: sync latency on last bit edge
        wr(2'd2, 8'h01);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        @(negedge clk); sdata_in = 1'b1; sck_in = 1'b0; addr = 2'd1;
        repeat (6) @(negedge clk);
        sck_in = 1'b1;
        @(negedge clk);
        @(negedge clk); #1 check("R8 not yet", rd_data, 8'h00);
        @(negedge clk); #1 check("R8 set", rd_data, 8'h01);
        repeat (6) @(negedge clk); sck_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, v); check("R8 byte", v, 8'h80);

        // R3 overrun: full still set, send another byte
        send_byte(8'h3C);
        rd(2'd0, v); check("R3 data kept", v, 8'h80);
        rd(2'd1, v); check("R3 status", v, 8'h03);
        check("R4 irq_err", {6'b0, irq_rx, irq_err}, 8'h03);

        // R5 halted: further frames ignored
        send_byte(8'h5A);
        rd(2'd0, v); check("R5 halted data", v, 8'h80);
        wr(2'd1, 8'hFD);   // clear overrun only, keep full
        rd(2'd1, v); check("R6 partial clear", v, 8'h01);
        send_byte(8'h11);
        rd(2'd0, v); check("R5 still halted", v, 8'h80);
        rd(2'd1, v); check("R5 no new overrun", v, 8'h01);
        wr(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        send_byte(8'h96);
        rd(2'd0, v); check("R5 resumed", v, 8'h96);
        wr(2'd1, 8'h00);

        // R6: writing ones never sets flags
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R6 write ones", v, 8'h00);

        // R7: partial frame discarded, flags kept
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        @(negedge clk); rx_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, v); check("R7 flags after drop", v, 8'h00);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_byte(8'h24);
        rd(2'd0, v); check("R7 fresh frame", v, 8'h24);
        @(negedge clk); rx_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, v); check("R7 full kept", v, 8'h01);

        // R11: start refused while full set
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_byte(8'hC3);
        rd(2'd0, v); check("R11 blocked start", v, 8'h24);
        rd(2'd1, v); check("R11 no overrun", v, 8'h01);
        rx_en = 1'b0;
        wr(2'd1, 8'h00);

        // R9: internal clock mode
        send_int(8'hB6, hc);
        rd(2'd0, v); check("R9 internal byte", v, 8'hB6);
        check("R9 half period", 8'(hc), 8'd4);
        check("R9 sck idle", {7'b0, sck_out}, 8'h00);

        // R4: enable off masks requests with flags set
        wr(2'd2, 8'h00);
        check("R4 masked", {6'b0, irq_rx, irq_err}, 8'h00);

        finish_up();
    end
endmodule